// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block paces the read and write strobes of one ATA channel, counting every interval in host clocks. It serves two drives on the channel, a master and a slave. For each transfer it picks one of two timings. Compatible timing uses fixed, conservative counts. Fast timing uses a programmable first ready-sample point and a programmable recovery time.

A host-side agent raises a request with a drive select, a direction, a data-port flag and a DMA flag. It keeps the request high until it sees a one-clock acknowledge. Once the strobe asserts, the block waits the chosen number of clocks before it first looks at the device ready line. It keeps the strobe active while the drive has ready sampling enabled and the line is low. It then holds the bus idle for the recovery interval before the next strobe may start.

The slave drive's fast-timing fields sit in a shared 8-bit register that covers both channels. A parameter selects which half this channel decodes. A per-channel enable decides whether the slave uses those fields or borrows the master's fields.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset both strobes (`dior_n`, `diow_n`) are high, `ack` is low and the slave timing register reads 8'h00.
- R2: Under fast timing the strobe stays low for the number of clocks given by the sample-point code: 2'b00 gives 5, 2'b01 gives 4 and 2'b10 gives 3, provided ready is high or ignored.
- R3: Sample-point code 2'b11 behaves exactly like 2'b10, giving a 3-clock strobe.
- R4: Under fast timing, the recovery code sets the number of clocks from the strobe's rising edge to the next strobe when a request is waiting: 2'b00 gives 4, 2'b01 gives 3, 2'b10 gives 2 and 2'b11 gives 1.
- R5: Compatible timing gives a 6-clock strobe and a 5-clock recovery. It applies when the drive's fast bit is clear, or when the access is not to the data port, whatever the fast bit says.
- R6: When a drive's DMA-only bit is set, fast timing applies only to its data-port cycles that carry the DMA flag. Its PIO data-port cycles use compatible timing. With the DMA-only bit clear, PIO data-port cycles use fast timing.
- R7: When the drive's ready-sample enable is set and ready is low at the sample point, the strobe stays low. Ready is re-sampled every clock. The strobe rises at the first clock edge that samples ready high, and `ack` is high for exactly the one clock that starts with that edge.
- R8: When the drive's ready-sample enable is clear, a low ready line has no effect, and the strobe width equals the programmed sample count.
- R9: For the slave drive (`req_drive`=1), fast timing uses the slave register fields when `cfg_slv_sel` is 1 and the master fields when it is 0. The master drive always uses the master fields.
- R10: A write to the slave register takes effect on the next clock. Bits [7:6]/[5:4] hold the secondary channel's sample/recovery codes and bits [3:2]/[1:0] hold the primary's. With CHANNEL=0 the primary pair is used.
- R11: A read request drives only `dior_n` and a write request drives only `diow_n`, never both. A request that is already waiting is accepted only once recovery has expired, and each request produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low reset |
| cfg_fast_en | input | 2 | Per-drive fast timing select (bit 0 master, bit 1 slave) |
| cfg_iordy_en | input | 2 | Per-drive ready-sample enable |
| cfg_dma_only | input | 2 | Per-drive fast-for-DMA-only bit |
| cfg_slv_sel | input | 1 | Slave drive uses slave register fields |
| mst_sample_code | input | 2 | Master sample-point code |
| mst_recov_code | input | 2 | Master recovery code |
| slv_wr_en | input | 1 | Slave timing register write strobe |
| slv_wr_data | input | 8 | Slave timing register write value |
| slv_tim_q | output | 8 | Slave timing register contents |
| req | input | 1 | Transfer request, held until ack |
| req_drive | input | 1 | 0 master, 1 slave |
| req_write | input | 1 | 1 write, 0 read |
| req_dataport | input | 1 | Access targets the data port |
| req_dma | input | 1 | Access is a DMA transfer |
| ack | output | 1 | One-clock completion pulse |
| iordy | input | 1 | Device ready line |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |

## Verification
Two events can meet on one clock edge: the recovery counter reaching zero and a request that has been waiting. With recovery code 2'b11, a request that stays high across the acknowledge is accepted on the very next edge. The strobe-to-strobe gap is measured in low clocks and must equal the programmed recovery, never more and never less. Back-to-back chains also change the timing fields on the clock of `ack`. The bench checks that the finished transfer's recovery is still honoured while the next transfer takes up the new fields.

// File: rtl/ata_tmg_pkg.sv
package ata_tmg_pkg;

  localparam int unsigned TMG_W = 4;

  typedef logic [TMG_W-1:0] tcnt_t;

  typedef struct packed {
    tcnt_t sample;
    tcnt_t recov;
  } tmg_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } seq_st_e;

  // first ready sample point: 5, 4, 3 clocks; reserved code treated as 3
  function automatic tcnt_t sample_clocks(input logic [1:0] code);
    case (code)
      2'b00:   sample_clocks = tcnt_t'(5);
      2'b01:   sample_clocks = tcnt_t'(4);
      default: sample_clocks = tcnt_t'(3);
    endcase
  endfunction

  // recovery gap: 4 down to 1 clocks
  function automatic tcnt_t recov_clocks(input logic [1:0] code);
    recov_clocks = tcnt_t'(3'd4 - {1'b0, code});
  endfunction

endpackage

// File: rtl/ata_tmg_slvreg.sv
module ata_tmg_slvreg #(
  parameter int unsigned CHANNEL = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] q,
  output logic [1:0] isp_code,
  output logic [1:0] rct_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 8'h00;
    else if (we) q <= wdata;
  end

  generate
    if (CHANNEL == 0) begin : g_primary
      assign isp_code = q[3:2];
      assign rct_code = q[1:0];
    end else begin : g_secondary
      assign isp_code = q[7:6];
      assign rct_code = q[5:4];
    end
  endgenerate

  assert_slv_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));

endmodule

// File: rtl/ata_tmg_sel.sv
module ata_tmg_sel
  import ata_tmg_pkg::*;
#(
  parameter int unsigned COMPAT_SAMPLE = 6,
  parameter int unsigned COMPAT_RECOV  = 5
) (
  input  logic       drive,
  input  logic       dataport,
  input  logic       dma,
  input  logic [1:0] fast_en,
  input  logic [1:0] dma_only,
  input  logic       slv_sel,
  input  logic [1:0] mst_isp,
  input  logic [1:0] mst_rct,
  input  logic [1:0] slv_isp,
  input  logic [1:0] slv_rct,
  output tmg_t       tmg,
  output logic       fast_use
);

  logic       use_slave;
  logic [1:0] isp_c;
  logic [1:0] rct_c;

  always_comb begin
    use_slave = drive & slv_sel;
    isp_c     = use_slave ? slv_isp : mst_isp;
    rct_c     = use_slave ? slv_rct : mst_rct;
    fast_use  = fast_en[drive] & dataport & (~dma_only[drive] | dma);
    if (fast_use) begin
      tmg.sample = sample_clocks(isp_c);
      tmg.recov  = recov_clocks(rct_c);
    end else begin
      tmg.sample = tcnt_t'(COMPAT_SAMPLE);
      tmg.recov  = tcnt_t'(COMPAT_RECOV);
    end
  end

endmodule

// File: rtl/ata_tmg_seq.sv
module ata_tmg_seq
  import ata_tmg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic req_write,
  input  logic rdy_en,
  input  tmg_t tmg,
  input  logic iordy,
  output logic dior_n,
  output logic diow_n,
  output logic ack,
  output logic accept,
  output logic sample_evt,
  output logic rec_zero
);

  seq_st_e state;
  tcnt_t   ph_cnt;
  tcnt_t   rec_cnt;
  tcnt_t   rec_q;
  logic    wr_q;
  logic    rdy_en_q;
  logic    strb;
  logic    ready_ok;

  assign rec_zero   = (rec_cnt == '0);
  assign accept     = (state == ST_IDLE) & req & rec_zero;
  assign sample_evt = (state == ST_ACTIVE) & (ph_cnt == '0);
  assign ready_ok   = ~rdy_en_q | iordy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ph_cnt   <= '0;
      rec_cnt  <= '0;
      rec_q    <= '0;
      wr_q     <= 1'b0;
      rdy_en_q <= 1'b0;
      strb     <= 1'b0;
      ack      <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_ACTIVE;
            ph_cnt   <= tmg.sample - tcnt_t'(1);
            rec_q    <= tmg.recov;
            wr_q     <= req_write;
            rdy_en_q <= rdy_en;
            strb     <= 1'b1;
          end else if (!rec_zero) begin
            rec_cnt <= rec_cnt - tcnt_t'(1);
          end
        end
        default: begin
          if (!sample_evt) begin
            ph_cnt <= ph_cnt - tcnt_t'(1);
          end else if (ready_ok) begin
            state   <= ST_IDLE;
            strb    <= 1'b0;
            ack     <= 1'b1;
            rec_cnt <= rec_q - tcnt_t'(1);
          end
        end
      endcase
    end
  end

  assign dior_n = ~(strb & ~wr_q);
  assign diow_n = ~(strb & wr_q);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  assert_ack_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $fell(strb));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_hold_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && rdy_en_q && !iordy) |=> strb);

  assert_ready_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && !rdy_en_q) |=> !strb);

  assert_recovery_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb) |-> $past(rec_zero));

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_tmg_pkg::*;
#(
  parameter int unsigned CHANNEL       = 0,
  parameter int unsigned COMPAT_SAMPLE = 6,
  parameter int unsigned COMPAT_RECOV  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_fast_en,
  input  logic [1:0] cfg_iordy_en,
  input  logic [1:0] cfg_dma_only,
  input  logic       cfg_slv_sel,
  input  logic [1:0] mst_sample_code,
  input  logic [1:0] mst_recov_code,
  input  logic       slv_wr_en,
  input  logic [7:0] slv_wr_data,
  output logic [7:0] slv_tim_q,
  input  logic       req,
  input  logic       req_drive,
  input  logic       req_write,
  input  logic       req_dataport,
  input  logic       req_dma,
  output logic       ack,
  input  logic       iordy,
  output logic       dior_n,
  output logic       diow_n
);

  logic [1:0] slv_isp;
  logic [1:0] slv_rct;
  tmg_t       tmg_cur;
  logic       fast_use;
  logic       accept;
  logic       sample_evt;
  logic       rec_zero;

  ata_tmg_slvreg #(.CHANNEL(CHANNEL)) slvreg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (slv_wr_en),
    .wdata    (slv_wr_data),
    .q        (slv_tim_q),
    .isp_code (slv_isp),
    .rct_code (slv_rct)
  );

  ata_tmg_sel #(
    .COMPAT_SAMPLE (COMPAT_SAMPLE),
    .COMPAT_RECOV  (COMPAT_RECOV)
  ) sel_i (
    .drive    (req_drive),
    .dataport (req_dataport),
    .dma      (req_dma),
    .fast_en  (cfg_fast_en),
    .dma_only (cfg_dma_only),
    .slv_sel  (cfg_slv_sel),
    .mst_isp  (mst_sample_code),
    .mst_rct  (mst_recov_code),
    .slv_isp  (slv_isp),
    .slv_rct  (slv_rct),
    .tmg      (tmg_cur),
    .fast_use (fast_use)
  );

  ata_tmg_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_write  (req_write),
    .rdy_en     (cfg_iordy_en[req_drive]),
    .tmg        (tmg_cur),
    .iordy      (iordy),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .ack        (ack),
    .accept     (accept),
    .sample_evt (sample_evt),
    .rec_zero   (rec_zero)
  );

  assert_compat_offport_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_dataport) |-> !fast_use);

  assert_dma_only_pio_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_dataport && !req_dma && cfg_dma_only[req_drive]) |-> !fast_use);

  assert_accept_leaves_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!dior_n || !diow_n));

endmodule

// File: tb/ata_pio_timer_tb_top.sv
module ata_pio_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_fast_en, cfg_iordy_en, cfg_dma_only;
  logic       cfg_slv_sel;
  logic [1:0] mst_sample_code, mst_recov_code;
  logic       slv_wr_en;
  logic [7:0] slv_wr_data, slv_tim_q;
  logic       req, req_drive, req_write, req_dataport, req_dma;
  logic       ack, iordy, dior_n, diow_n;

  always #5 clk = ~clk;

  ata_pio_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_fast_en(cfg_fast_en), .cfg_iordy_en(cfg_iordy_en),
    .cfg_dma_only(cfg_dma_only), .cfg_slv_sel(cfg_slv_sel),
    .mst_sample_code(mst_sample_code), .mst_recov_code(mst_recov_code),
    .slv_wr_en(slv_wr_en), .slv_wr_data(slv_wr_data), .slv_tim_q(slv_tim_q),
    .req(req), .req_drive(req_drive), .req_write(req_write),
    .req_dataport(req_dataport), .req_dma(req_dma), .ack(ack),
    .iordy(iordy), .dior_n(dior_n), .diow_n(diow_n)
  );

  typedef struct {
    int    width;
    bit    wr;
    int    gap;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   chained  = 1'b0;
  int   last_r   = 0;
  bit   reported = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  // bench view of the code tables
  function automatic int first_sample(input logic [1:0] c);
    return (c == 2'b11) ? 3 : 5 - int'(c);
  endfunction
  function automatic int gap_of(input logic [1:0] c);
    return 4 - int'(c);
  endfunction

  // monitor: measures strobe pulses and compares with the scoreboard
  bit prev_strb = 1'b0;
  bit prev_ack  = 1'b0;
  int hi_cnt    = 0;
  int lo_cnt    = 0;
  int gap_seen  = 0;
  bit wr_seen   = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!dior_n || !diow_n) begin
        if (!prev_strb) begin
          gap_seen = lo_cnt;
          wr_seen  = !diow_n;
          hi_cnt   = 0;
        end
        hi_cnt++;
        prev_strb = 1'b1;
      end else begin
        if (prev_strb) begin
          chk(ack === 1'b1, "R7", "ack at strobe release", int'(ack), 1);
          if (sb.size() == 0) begin
            chk(1'b0, "R11", "unexpected strobe", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            chk(hi_cnt == e.width, e.tag, "strobe width", hi_cnt, e.width);
            chk(wr_seen == e.wr, "R11", "strobe line (1=write)", int'(wr_seen), int'(e.wr));
            if (e.gap >= 0)
              chk(gap_seen == e.gap, e.tag, "recovery gap", gap_seen, e.gap);
          end
          lo_cnt = 0;
        end
        lo_cnt++;
        prev_strb = 1'b0;
      end
      if (prev_ack && ack) chk(1'b0, "R7", "ack longer than one clock", 2, 1);
      prev_ack = ack;
    end
  end

  // driver: called at a negedge, leaves req high on return
  task automatic xfer(input bit drv, input bit wr, input bit dp, input bit dma,
                      input int w, input int r, input string tag);
    exp_t e;
    e.width = w;
    e.wr    = wr;
    e.gap   = chained ? last_r : -1;
    e.tag   = tag;
    sb.push_back(e);
    req_drive    = drv;
    req_write    = wr;
    req_dataport = dp;
    req_dma      = dma;
    req          = 1'b1;
    do @(negedge clk); while (ack !== 1'b1);
    chained = 1'b1;
    last_r  = r;
  endtask

  task automatic release_req();
    req     = 1'b0;
    chained = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic stall(input int s, input int n);
    do @(negedge clk); while (dior_n && diow_n);
    repeat (s + n - 1) @(negedge clk);
    iordy = 1'b1;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "R11", "watchdog expired", 1, 0);
    report();
  end

  initial begin
    rst_n = 1'b0;
    cfg_fast_en = 2'b00; cfg_iordy_en = 2'b11; cfg_dma_only = 2'b00;
    cfg_slv_sel = 1'b0; mst_sample_code = 2'b00; mst_recov_code = 2'b00;
    slv_wr_en = 1'b0; slv_wr_data = 8'h00;
    req = 1'b0; req_drive = 1'b0; req_write = 1'b0; req_dataport = 1'b1; req_dma = 1'b0;
    iordy = 1'b1;
    repeat (3) @(negedge clk);
    chk(dior_n === 1'b1 && diow_n === 1'b1, "R1", "strobes idle high", int'({dior_n, diow_n}), 3);
    chk(ack === 1'b0, "R1", "ack low", int'(ack), 0);
    chk(slv_tim_q === 8'h00, "R1", "slave register reset", int'(slv_tim_q), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5: compatible timing with the fast bit clear; R11 held request
    xfer(0, 0, 1, 0, 6, 5, "R5");
    xfer(0, 1, 1, 0, 6, 5, "R11");
    release_req();

    // R2 / R4: fast timing, fields changed on the ack clock
    cfg_fast_en = 2'b01;
    mst_sample_code = 2'b00; mst_recov_code = 2'b00;
    xfer(0, 0, 1, 0, first_sample(2'b00), gap_of(2'b00), "R2");
    mst_sample_code = 2'b01; mst_recov_code = 2'b01;
    xfer(0, 1, 1, 0, first_sample(2'b01), gap_of(2'b01), "R2");
    mst_sample_code = 2'b10; mst_recov_code = 2'b10;
    xfer(0, 0, 1, 0, first_sample(2'b10), gap_of(2'b10), "R4");
    mst_sample_code = 2'b11; mst_recov_code = 2'b11;
    xfer(0, 0, 1, 0, 3, gap_of(2'b11), "R3");
    mst_sample_code = 2'b00; mst_recov_code = 2'b00;
    xfer(0, 1, 1, 0, 5, 4, "R4");
    release_req();

    // R5: not the data port, fast bit ignored
    xfer(0, 0, 0, 0, 6, 5, "R5");
    xfer(0, 0, 0, 1, 6, 5, "R5");
    release_req();

    // R6: DMA-only
    cfg_dma_only = 2'b01; mst_sample_code = 2'b10; mst_recov_code = 2'b11;
    xfer(0, 0, 1, 0, 6, 5, "R6");
    xfer(0, 0, 1, 1, 3, 1, "R6");
    cfg_dma_only = 2'b00;
    xfer(0, 1, 1, 0, 3, 1, "R6");
    release_req();

    // R8: slave drive with ready sampling off, ready held low
    cfg_fast_en = 2'b11; cfg_iordy_en = 2'b01; iordy = 1'b0;
    xfer(1, 0, 1, 0, 3, 1, "R8");
    release_req();
    iordy = 1'b1; cfg_iordy_en = 2'b11;

    // R7: ready low for two samples on the master
    iordy = 1'b0;
    fork stall(3, 2); join_none
    xfer(0, 1, 1, 0, 5, 1, "R7");
    release_req();
    iordy = 1'b1;

    // R10: slave register write and field positions (0xB4: primary sample 01, recov 00)
    slv_wr_data = 8'hB4; slv_wr_en = 1'b1;
    @(negedge clk);
    slv_wr_en = 1'b0;
    chk(slv_tim_q === 8'hB4, "R10", "slave register write", int'(slv_tim_q), 'hB4);

    // R9: slave uses its own fields only when selected
    cfg_slv_sel = 1'b1; mst_sample_code = 2'b00; mst_recov_code = 2'b00;
    xfer(1, 0, 1, 0, 4, 4, "R10");
    xfer(0, 0, 1, 0, 5, 4, "R9");
    xfer(1, 1, 1, 0, 4, 4, "R9");
    cfg_slv_sel = 1'b0;
    xfer(1, 0, 1, 0, 5, 4, "R9");
    release_req();

    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R11", "every request produced one strobe", sb.size(), 0);
    report();
  end

endmodule